// File: doc/BRIEF.md
# Packed Instruction Register-File Sequencer

This block sits in the first half of decode. Fetch hands it one packed word, which holds five 5-bit slots. Each slot either names an entry of a 32-entry instruction register file, pads the pack with a nop (value 0), or, when its flag bit is set, carries a parameter for an earlier instruction. The sequencer expands the live slots into full 32-bit instructions and issues them to the decoder one per cycle, in slot order. It holds fetch stalled until the pack is used up.

A parameter changes how the instruction it belongs to is expanded. For an I-type entry the parameter selects an immediate from a 32-entry side table. For an R-type entry it replaces the destination register. For a branch it becomes a signed 5-bit displacement. After a branch issues with slots still pending, the sequencer waits for the branch outcome. Those slots then run only on the fall-through path of a forward branch, or only on the taken path of a backward branch. This gives predicated execution with no predicate bits. A write port fills the register file and the immediate table, and a flush drops whatever pack is in flight.

Top module: `pack_issue_seq`

## Requirements
- R1: A pack is accepted on a rising edge where `pack_valid` is high and `fetch_stall` is low. Its live slots are issued one per cycle, lowest slot first, starting in the cycle after acceptance. Slot i is `pack_word[5i+4:5i]`, and the flag of slot i is `pack_word[25+i]`.
- R2: An unflagged slot holding 0 is a nop. It is skipped without issuing and without costing a cycle. A pack with no live slot issues nothing and leaves `fetch_stall` low.
- R3: A flagged slot is a parameter and is never issued. It applies to the nearest lower-numbered live slot. Only the two lowest flagged slots count; any further flagged slot behaves as a nop. A parameter with no earlier live slot is dropped.
- R4: For an entry of kind 01 or 11 (kind = bits [31:30]), a parameter sets bits [14:0] to the immediate-table entry it indexes. Without a parameter, the entry's own bits [14:0] (its default immediate) are issued unchanged.
- R5: For an entry of kind 00 (R-type), a parameter replaces the destination field, bits [29:25], and the immediate stays unchanged.
- R6: For an entry of kind 10 (branch), a parameter sets bits [14:0] to its 5-bit value sign-extended. The branch counts as backward when bit 14 of the issued instruction is 1, and forward otherwise.
- R7: After a forward branch issues with live slots remaining, nothing is issued until `br_valid`. If the branch is not taken, issue resumes in the next cycle. If it is taken, the rest of the pack is annulled.
- R8: After a backward branch with live slots remaining, the rule is reversed: a taken branch resumes issue and a not-taken branch annuls the rest.
- R9: `fetch_stall` is high while live slots remain. It is low in the cycle the last live slot issues, in the cycle an annulling outcome arrives, and whenever the block is idle.
- R10: `flush` forces `dec_valid` and `fetch_stall` low in the same cycle. It discards the pack and its parameters, so nothing from that pack issues afterwards.
- R11: A write with `wr_sel`=0 loads instruction entry `wr_addr` with `wr_data`. A write with `wr_sel`=1 loads immediate entry `wr_addr` with `wr_data[14:0]`. Either write takes effect from the next cycle.
- R12: During and right after reset, `dec_valid` and `fetch_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush, drops the current pack |
| pack_valid | input | 1 | Packed word present from fetch |
| pack_word | input | 30 | Five slot fields plus five parameter flags |
| br_valid | input | 1 | Outcome of the last issued branch is available |
| br_taken | input | 1 | That branch was taken |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 selects the instruction file, 1 the immediate table |
| wr_addr | input | 5 | Table entry to write |
| wr_data | input | 32 | Write data |
| dec_valid | output | 1 | An expanded instruction is presented this cycle |
| dec_instr | output | 32 | Expanded instruction |
| fetch_stall | output | 1 | Hold fetch |

## Verification
The bench places nop slots in the middle of a pack, and also sends a pack that holds only a parameter. A design that charged a cycle for a nop, or issued a parameter, would show an extra or wrong issue.

Three parameters are sent after the same two instructions, so a design that honoured the third would issue a wrong immediate. A negative parameter is used to turn a forward-defaulted branch into a backward one. This catches direction logic that reads the default instead of the substituted displacement.

All four outcome combinations are run, along with a branch in the last slot, which must not wait. A flush mid-pack and a back-to-back pack accepted in the last issue cycle catch stale slots or a stall that drops one cycle too late.

// File: rtl/pack_issue_seq.sv
module pack_issue_seq #(
  parameter int SLOTS = 5,
  parameter int IDXW  = 5,
  parameter int INSW  = 32,
  parameter int IMMW  = 15,
  parameter int MAXPAR = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        pack_valid,
  input  logic [SLOTS*IDXW+SLOTS-1:0] pack_word,
  input  logic                        br_valid,
  input  logic                        br_taken,
  input  logic                        wr_en,
  input  logic                        wr_sel,
  input  logic [IDXW-1:0]             wr_addr,
  input  logic [INSW-1:0]             wr_data,
  output logic                        dec_valid,
  output logic [INSW-1:0]             dec_instr,
  output logic                        fetch_stall
);
  localparam int ENTRIES = 1 << IDXW;
  localparam int SW      = $clog2(SLOTS);
  localparam int FLAG0   = SLOTS * IDXW;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} st_t;

  st_t st_q, st_d;
  logic [INSW-1:0] irf  [ENTRIES];
  logic [IMMW-1:0] immt [ENTRIES];
  logic [IDXW-1:0] idx_q [SLOTS];
  logic [IDXW-1:0] pv_q  [SLOTS];
  logic [IDXW-1:0] ld_pv [SLOTS];
  logic [SLOTS-1:0] live_q, hp_q, ld_live, ld_hp, live_d;
  logic [SLOTS-1:0] cur_oh, remaining;
  logic [SW-1:0] cur;
  logic bwd_q;

  always_ff @(posedge clk) begin
    if (wr_en && !wr_sel) irf[wr_addr] <= wr_data;
    if (wr_en && wr_sel)  immt[wr_addr] <= wr_data[IMMW-1:0];
  end

  always_comb begin : ld_dec
    logic [SW-1:0] own;
    logic own_v;
    logic [1:0] npar;
    ld_live = '0;
    ld_hp   = '0;
    own     = '0;
    own_v   = 1'b0;
    npar    = '0;
    for (int i = 0; i < SLOTS; i++) ld_pv[i] = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (pack_word[FLAG0+i]) begin
        if (32'(npar) < MAXPAR) begin
          if (own_v) begin
            ld_hp[own] = 1'b1;
            ld_pv[own] = pack_word[i*IDXW +: IDXW];
          end
          npar = npar + 2'd1;
        end
      end else if (pack_word[i*IDXW +: IDXW] != '0) begin
        ld_live[i] = 1'b1;
        own   = SW'(i);
        own_v = 1'b1;
      end
    end
  end

  always_comb begin
    cur = '0;
    for (int i = SLOTS-1; i >= 0; i--)
      if (live_q[i]) cur = SW'(i);
  end

  assign cur_oh    = live_q & (~live_q + 1'b1);
  assign remaining = live_q & ~cur_oh;

  logic [INSW-1:0] entry, ins;
  logic [1:0] kind;
  logic [IDXW-1:0] par;
  assign entry = irf[idx_q[cur]];
  assign kind  = entry[INSW-1 -: 2];
  assign par   = pv_q[cur];

  always_comb begin
    ins = entry;
    if (hp_q[cur]) begin
      case (kind)
        2'b00:   ins[INSW-3 -: IDXW] = par;
        2'b10:   ins[IMMW-1:0] = {{(IMMW-IDXW){par[IDXW-1]}}, par};
        default: ins[IMMW-1:0] = immt[par];
      endcase
    end
  end

  logic issuing, rest_any, is_br, cont, accept;
  assign issuing  = (st_q == S_RUN) && !flush;
  assign rest_any = |remaining;
  assign is_br    = (kind == 2'b10);
  assign cont     = bwd_q ? br_taken : !br_taken;

  always_comb begin
    fetch_stall = 1'b0;
    if (!flush) begin
      case (st_q)
        S_RUN:   fetch_stall = rest_any;
        S_WAIT:  fetch_stall = !br_valid || cont;
        default: fetch_stall = 1'b0;
      endcase
    end
  end

  assign accept    = pack_valid && !fetch_stall && !flush;
  assign dec_valid = issuing;
  assign dec_instr = ins;

  always_comb begin
    st_d   = st_q;
    live_d = live_q;
    case (st_q)
      S_RUN: begin
        live_d = remaining;
        if (!rest_any)  st_d = S_IDLE;
        else if (is_br) st_d = S_WAIT;
      end
      S_WAIT: if (br_valid) begin
        if (cont) st_d = S_RUN;
        else begin
          st_d   = S_IDLE;
          live_d = '0;
        end
      end
      default: ;
    endcase
    if (accept) begin
      live_d = ld_live;
      st_d   = (|ld_live) ? S_RUN : S_IDLE;
    end
    if (flush) begin
      live_d = '0;
      st_d   = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      live_q <= '0;
      hp_q   <= '0;
      bwd_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      live_q <= live_d;
      if (flush) hp_q <= '0;
      else if (accept) hp_q <= ld_hp;
      if (issuing && is_br) bwd_q <= ins[IMMW-1];
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < SLOTS; i++) begin
        idx_q[i] <= pack_word[i*IDXW +: IDXW];
        pv_q[i]  <= ld_pv[i];
      end
    end
  end

  // R2
  no_nop_issue_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (idx_q[cur] != '0));

  // R1
  live_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_RUN && !flush && !accept) |=>
      ($countones(live_q) + 1 == $countones($past(live_q))));

  // R7
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_WAIT) |-> !dec_valid);

  // R9
  stall_release_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !fetch_stall && !pack_valid) |=> !dec_valid);

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !dec_valid);

  // R10
  flush_now_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!dec_valid && !fetch_stall));
endmodule

// File: tb/sim_pack_issue_seq.sv
module sim_pack_issue_seq;
  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic pack_valid = 1'b0, br_valid = 1'b0, br_taken = 1'b0;
  logic [29:0] pack_word = '0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic dec_valid, fetch_stall;
  logic [31:0] dec_instr;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pack_issue_seq u0 (
    .clk(clk), .rst(rst), .flush(flush), .pack_valid(pack_valid),
    .pack_word(pack_word), .br_valid(br_valid), .br_taken(br_taken),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .dec_valid(dec_valid), .dec_instr(dec_instr), .fetch_stall(fetch_stall)
  );

  localparam logic [31:0] E1 = {2'b00, 5'd3, 5'd1, 5'd2, 15'd0};
  localparam logic [31:0] E2 = {2'b01, 5'd4, 5'd4, 5'd0, 15'd7};
  localparam logic [31:0] E3 = {2'b10, 5'd0, 5'd1, 5'd2, 15'd3};
  localparam logic [31:0] E4 = {2'b10, 5'd0, 5'd1, 5'd2, 15'h7FFE};
  localparam logic [31:0] E5 = {2'b01, 5'd5, 5'd5, 5'd0, 15'd9};

  function automatic logic [29:0] mk(input logic [4:0] s0, s1, s2, s3, s4,
                                     input logic [4:0] fl);
    return {fl, s4, s3, s2, s1, s0};
  endfunction

  function automatic logic [31:0] with_imm(input logic [31:0] e, input logic [14:0] v);
    return {e[31:15], v};
  endfunction

  task automatic step(input string tag, input logic pv, input logic [29:0] pw,
                      input logic bv, input logic bt, input logic fl,
                      input logic ev, input logic [31:0] ei, input logic es);
    @(negedge clk);
    pack_valid = pv; pack_word = pw; br_valid = bv; br_taken = bt; flush = fl;
    #1;
    n_chk++;
    if (dec_valid !== ev || fetch_stall !== es || (ev && dec_instr !== ei)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b instr=%h stall=%0b, expected valid=%0b instr=%h stall=%0b",
               tag, dec_valid, dec_instr, fetch_stall, ev, ei, es);
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic load(input string tag, input logic [29:0] pw);
    step(tag, 1'b1, pw, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic issue(input string tag, input logic [31:0] ei, input logic es);
    step(tag, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, ei, es);
  endtask

  task automatic outcome(input string tag, input logic bt, input logic es);
    step(tag, 1'b0, '0, 1'b1, bt, 1'b0, 1'b0, '0, es);
  endtask

  task automatic wr(input logic sel, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    n_chk++;
    if (dec_valid !== 1'b0 || fetch_stall !== 1'b0) begin
      n_fail++;
      $display("FAIL R12: valid=%0b stall=%0b, expected 0 0", dec_valid, fetch_stall);
    end
  endtask

  task automatic t_seq;
    load("R1 load", mk(5'd1, 5'd2, 5'd5, 0, 0, 5'b0));
    issue("R1 slot0", E1, 1'b1);
    issue("R1 slot1", E2, 1'b1);
    issue("R4 default imm R9 last", E5, 1'b0);
    idle("R9 idle after pack");
  endtask

  task automatic t_nops;
    load("R2 load", mk(0, 5'd1, 0, 0, 5'd2, 5'b0));
    issue("R2 skip lead nop", E1, 1'b1);
    issue("R2 skip mid nops", E2, 1'b0);
    idle("R2 done");
    load("R2 param only", mk(0, 5'd3, 0, 0, 0, 5'b00010));
    idle("R2 R3 empty pack");
  endtask

  task automatic t_params;
    load("R3 load", mk(5'd2, 5'd6, 5'd1, 5'd9, 0, 5'b01010));
    issue("R4 param imm", with_imm(E2, 15'h1234), 1'b1);
    issue("R5 rd replaced", {E1[31:30], 5'd9, E1[24:0]}, 1'b0);
    idle("R3 params not issued");
    load("R3 third param", mk(5'd2, 5'd6, 5'd5, 5'd2, 5'd12, 5'b11010));
    issue("R3 first param", with_imm(E2, 15'h1234), 1'b1);
    issue("R3 third ignored", with_imm(E5, 15'h0042), 1'b0);
    idle("R3 done");
  endtask

  task automatic t_fwd;
    load("R7 load nt", mk(5'd3, 5'd2, 5'd1, 0, 0, 5'b0));
    issue("R7 branch", E3, 1'b1);
    outcome("R7 not taken resumes", 1'b0, 1'b1);
    issue("R7 after nt", E2, 1'b1);
    issue("R7 last", E1, 1'b0);
    idle("R7 done");
    load("R7 load tk", mk(5'd3, 5'd2, 5'd1, 0, 0, 5'b0));
    issue("R7 branch tk", E3, 1'b1);
    outcome("R7 taken annuls", 1'b1, 1'b0);
    idle("R7 annulled");
    load("R7 tail branch", mk(5'd1, 5'd3, 0, 0, 0, 5'b0));
    issue("R7 tail pre", E1, 1'b1);
    issue("R7 tail branch no wait", E3, 1'b0);
    idle("R7 tail done");
  endtask

  task automatic t_bwd;
    load("R8 load tk", mk(5'd4, 5'd2, 0, 0, 0, 5'b0));
    issue("R8 branch", E4, 1'b1);
    outcome("R8 taken resumes", 1'b1, 1'b1);
    issue("R8 after taken", E2, 1'b0);
    idle("R8 done");
    load("R8 load nt", mk(5'd4, 5'd2, 0, 0, 0, 5'b0));
    issue("R8 branch nt", E4, 1'b1);
    outcome("R8 not taken annuls", 1'b0, 1'b0);
    idle("R8 annulled");
  endtask

  task automatic t_disp;
    load("R6 load", mk(5'd3, 5'd30, 5'd2, 0, 0, 5'b00010));
    issue("R6 displacement", with_imm(E3, 15'h7FFE), 1'b1);
    outcome("R6 now backward taken", 1'b1, 1'b1);
    issue("R6 resumes", E2, 1'b0);
    idle("R6 done");
  endtask

  task automatic t_flush;
    load("R10 load", mk(5'd1, 5'd2, 5'd5, 0, 0, 5'b0));
    issue("R10 first", E1, 1'b1);
    step("R10 flush cycle", 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    idle("R10 after flush");
  endtask

  task automatic t_b2b;
    load("R1 b2b load", mk(5'd1, 5'd2, 0, 0, 0, 5'b0));
    issue("R1 b2b first", E1, 1'b1);
    step("R9 accept on last", 1'b1, mk(5'd5, 0, 0, 0, 0, 5'b0),
         1'b0, 1'b0, 1'b0, 1'b1, E2, 1'b0);
    issue("R1 b2b second pack", E5, 1'b0);
    idle("R1 b2b done");
  endtask

  task automatic t_write;
    wr(1'b0, 5'd7, E5);
    wr(1'b1, 5'd6, 32'hFFFF_0555);
    load("R11 load", mk(5'd7, 5'd6, 0, 0, 0, 5'b00010));
    issue("R11 tables rewritten", with_imm(E5, 15'h0555), 1'b0);
    idle("R11 done");
    wr(1'b1, 5'd6, 32'h0000_1234);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    @(negedge clk);
    rst = 1'b0;
    #1 t_reset();
    wr(1'b0, 5'd1, E1);
    wr(1'b0, 5'd2, E2);
    wr(1'b0, 5'd3, E3);
    wr(1'b0, 5'd4, E4);
    wr(1'b0, 5'd5, E5);
    wr(1'b1, 5'd6, 32'h0000_1234);
    wr(1'b1, 5'd2, 32'h0000_0042);
    wr(1'b1, 5'd12, 32'h0000_0777);
    t_seq();
    t_nops();
    t_params();
    t_fwd();
    t_bwd();
    t_disp();
    t_flush();
    t_b2b();
    t_write();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule